// File: doc/BRIEF.md
# MSI Vector Capture Register

This block turns message-signalled interrupt writes into pending interrupt bits. It watches an inbound write channel (address, data and a valid strobe). A write goes to the configured MSI target address when its address matches that address. For such a write, the data word is read as a vector number, and the matching bit of a 32-bit pending register is set. Inbound writes to any other address pass by and leave the register alone.

Software sees the pending vectors through a small register port. A read at the status offset returns the pending word. A write at the same offset clears every bit written as 1 and leaves bits written as 0 alone. One registered summary output is high while any vector is pending. It is meant to drive the MSI bit of a second-level local interrupt status word.

Top module: `msi_vector_capture`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge), the pending word is all zeros, `msi_pending_any` is 0 and `reg_rdata` is 0.
- R2: An inbound write with `wr_valid` high, `wr_addr` equal to `MSI_TARGET_ADDR` (default 0x190) and `wr_data` = v, where v < `NUM_VEC` (32), sets pending bit v at that clock edge. All other bits keep their values.
- R3: A matching inbound write whose `wr_data` is `NUM_VEC` or greater sets no pending bit.
- R4: An inbound write whose address differs from `MSI_TARGET_ADDR` sets no pending bit.
- R5: A register write at `STATUS_OFS` (default 0x194) clears each pending bit whose `reg_wdata` bit is 1. Bits whose `reg_wdata` bit is 0 are unchanged.
- R6: When an MSI write sets a bit at the same edge as a register write clears it, the bit ends up set. Other bits named in the clear are still cleared.
- R7: `msi_pending_any` is 1 exactly when the pending word is non-zero. It changes at the same edge as the pending word.
- R8: A register read (`reg_rd_en` high) at `STATUS_OFS` presents the pending word, as it stood before that edge, on `reg_rdata` in the next cycle, zero-extended. A read at `TARGET_OFS` (default 0x190) returns `MSI_TARGET_ADDR`. A read at any other offset, and any cycle with no read, gives 0.
- R9: A register write at any offset other than `STATUS_OFS` changes no pending bit.
- R10: An inbound write with `wr_valid` low sets no pending bit, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Inbound write strobe |
| wr_addr | input | ADDR_W (32) | Inbound write address |
| wr_data | input | DATA_W (32) | Inbound write data (vector number) |
| reg_addr | input | REG_AW (12) | Register port offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | REG_DW (32) | Register write data (1 bits clear vectors) |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rdata | output | REG_DW (32) | Registered read data, valid the cycle after the read |
| msi_pending_any | output | 1 | Registered summary: any vector pending |

## Verification
The bench builds the block with its default parameters: 32 vectors, a 32-bit inbound address and data word, and target and status offsets of 0x190 and 0x194. With 32 vectors, every vector index can be set, read back and cleared one at a time. All data values from 32 to 63 are tried, plus the top of the word, to show that out-of-range vectors are dropped. The same-edge race between set and clear is run for several bit positions. Before each step, the pending word, the summary and the read data are predicted from a bit-mask model.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  // Register port targets decoded from the offset
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_TARGET = 2'd2
  } reg_sel_e;

  // Default placement of the two software-visible locations
  localparam int unsigned DEF_TARGET_OFS = 32'h190;
  localparam int unsigned DEF_STATUS_OFS = 32'h194;

endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned NUM_VEC         = 32,
  parameter logic [ADDR_W-1:0] TARGET    = ADDR_W'(32'h190)
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [NUM_VEC-1:0] set_vec
);

  logic addr_ok;
  logic range_ok;

  always_comb begin
    addr_ok  = (wr_addr == TARGET);
    range_ok = (wr_data < DATA_W'(NUM_VEC));
    hit      = wr_valid && addr_ok && range_ok;
  end

  // One comparator per vector; the range check guards against aliasing
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_dec
    assign set_vec[gi] = hit && (wr_data == DATA_W'(gi));
  end

endmodule

// File: rtl/msi_reg_port.sv
module msi_reg_port
  import msi_cap_pkg::*;
#(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned REG_DW     = 32,
  parameter int unsigned NUM_VEC    = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] TARGET = ADDR_W'(32'h190),
  parameter int unsigned TARGET_OFS = DEF_TARGET_OFS,
  parameter int unsigned STATUS_OFS = DEF_STATUS_OFS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr_en,
  input  logic [REG_DW-1:0]  reg_wdata,
  input  logic               reg_rd_en,
  input  logic [NUM_VEC-1:0] pending,
  output logic [NUM_VEC-1:0] clr_mask,
  output logic [REG_DW-1:0]  reg_rdata
);

  localparam logic [REG_AW-1:0] STATUS_A = REG_AW'(STATUS_OFS);
  localparam logic [REG_AW-1:0] TARGET_A = REG_AW'(TARGET_OFS);

  reg_sel_e            sel;
  logic [REG_DW-1:0]   rd_next;

  always_comb begin
    if (reg_addr == STATUS_A)      sel = SEL_STATUS;
    else if (reg_addr == TARGET_A) sel = SEL_TARGET;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    clr_mask = '0;
    if (reg_wr_en && sel == SEL_STATUS)
      clr_mask = reg_wdata[NUM_VEC-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (reg_rd_en) begin
      case (sel)
        SEL_STATUS: rd_next = REG_DW'(pending);
        SEL_TARGET: rd_next = REG_DW'(TARGET);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

endmodule

// File: rtl/msi_pending_bank.sv
module msi_pending_bank #(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] set_vec,
  input  logic [NUM_VEC-1:0] clr_mask,
  output logic [NUM_VEC-1:0] pending,
  output logic               any_pending
);

  logic [NUM_VEC-1:0] nxt;

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_bit
    // Arrival beats clear on the same edge
    assign nxt[gi] = set_vec[gi] | (pending[gi] & ~clr_mask[gi]);

    always_ff @(posedge clk) begin
      if (rst) pending[gi] <= 1'b0;
      else     pending[gi] <= nxt[gi];
    end
  end

  // Summary taken from next state so it moves with the pending word
  always_ff @(posedge clk) begin
    if (rst) any_pending <= 1'b0;
    else     any_pending <= |nxt;
  end

endmodule

// File: rtl/msi_vector_capture.sv
module msi_vector_capture
  import msi_cap_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned NUM_VEC      = 32,
  parameter int unsigned REG_AW       = 12,
  parameter int unsigned REG_DW       = 32,
  parameter logic [ADDR_W-1:0] MSI_TARGET_ADDR = ADDR_W'(32'h190),
  parameter int unsigned TARGET_OFS   = DEF_TARGET_OFS,
  parameter int unsigned STATUS_OFS   = DEF_STATUS_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_rd_en,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              msi_pending_any
);

  logic               msi_hit;
  logic [NUM_VEC-1:0] set_vec;
  logic [NUM_VEC-1:0] clr_mask;
  logic [NUM_VEC-1:0] pending_q;

  msi_addr_match #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_VEC(NUM_VEC),
    .TARGET (MSI_TARGET_ADDR)
  ) u_match (
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hit     (msi_hit),
    .set_vec (set_vec)
  );

  msi_reg_port #(
    .REG_AW    (REG_AW),
    .REG_DW    (REG_DW),
    .NUM_VEC   (NUM_VEC),
    .ADDR_W    (ADDR_W),
    .TARGET    (MSI_TARGET_ADDR),
    .TARGET_OFS(TARGET_OFS),
    .STATUS_OFS(STATUS_OFS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en),
    .pending  (pending_q),
    .clr_mask (clr_mask),
    .reg_rdata(reg_rdata)
  );

  msi_pending_bank #(
    .NUM_VEC(NUM_VEC)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_vec    (set_vec),
    .clr_mask   (clr_mask),
    .pending    (pending_q),
    .any_pending(msi_pending_any)
  );

endmodule

// File: rtl/msi_vector_capture_chk.sv
module msi_vector_capture_chk #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned NUM_VEC      = 32,
  parameter int unsigned REG_AW       = 12,
  parameter int unsigned REG_DW       = 32,
  parameter logic [ADDR_W-1:0] MSI_TARGET_ADDR = ADDR_W'(32'h190),
  parameter int unsigned STATUS_OFS   = 32'h194
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [REG_AW-1:0]  reg_addr,
  input logic               reg_wr_en,
  input logic [REG_DW-1:0]  reg_wdata,
  input logic               reg_rd_en,
  input logic [REG_DW-1:0]  reg_rdata,
  input logic               msi_pending_any,
  input logic [NUM_VEC-1:0] pending
);

  localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam logic [REG_AW-1:0] STATUS_A = REG_AW'(STATUS_OFS);

  logic acc;
  logic clr_wr;
  assign acc    = wr_valid && (wr_addr == MSI_TARGET_ADDR) && (wr_data < DATA_W'(NUM_VEC));
  assign clr_wr = reg_wr_en && (reg_addr == STATUS_A);

  // R2 R6
  vec_set_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> pending[$past(wr_data[IDX_W-1:0])]);

  // R3 R4 R10
  no_stray_set_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ((pending & ~$past(pending)) == '0));

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !wr_valid) |=> ((pending & $past(reg_wdata[NUM_VEC-1:0])) == '0));

  // R5 R9
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((~pending & $past(pending)) == '0));

  // R7
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    msi_pending_any == (pending != '0));

  // R8
  status_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == STATUS_A) |=> (reg_rdata == REG_DW'($past(pending))));

endmodule

bind msi_vector_capture msi_vector_capture_chk #(
  .ADDR_W         (ADDR_W),
  .DATA_W         (DATA_W),
  .NUM_VEC        (NUM_VEC),
  .REG_AW         (REG_AW),
  .REG_DW         (REG_DW),
  .MSI_TARGET_ADDR(MSI_TARGET_ADDR),
  .STATUS_OFS     (STATUS_OFS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_valid       (wr_valid),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .reg_addr       (reg_addr),
  .reg_wr_en      (reg_wr_en),
  .reg_wdata      (reg_wdata),
  .reg_rd_en      (reg_rd_en),
  .reg_rdata      (reg_rdata),
  .msi_pending_any(msi_pending_any),
  .pending        (pending_q)
);

// File: tb/msi_vector_capture_tb.sv
`timescale 1ns/1ps
module msi_vector_capture_tb_top;

  localparam logic [31:0] TGT = 32'h190;
  localparam logic [11:0] STS = 12'h194;
  localparam logic [11:0] TOF = 12'h190;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic [11:0] reg_addr;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic        reg_rd_en;
  logic [31:0] reg_rdata;
  logic        msi_pending_any;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  msi_vector_capture dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .msi_pending_any(msi_pending_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 0; wr_addr = '0; wr_data = '0;
    reg_addr = '0; reg_wr_en = 0; reg_wdata = '0; reg_rd_en = 0;
  endtask

  // one cycle with optional MSI and optional clear write
  task automatic cycle(input bit v, input logic [31:0] a, input logic [31:0] d,
                       input bit w, input logic [11:0] ra, input logic [31:0] wd);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d;
    reg_wr_en = w; reg_addr = ra; reg_wdata = wd;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [11:0] ra, output logic [31:0] val);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = ra;
    @(negedge clk);
    val = reg_rdata;
    idle();
  endtask

  task automatic check_state(input string req);
    logic [31:0] r;
    check({req, " summary"}, {31'b0, msi_pending_any}, {31'b0, model != 0});
    rd(STS, r);
    check({req, " pending"}, r, model);
  endtask

  initial begin
    logic [31:0] r;
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 summary", {31'b0, msi_pending_any}, 32'h0);
    rd(STS, r); check("R1 pending", r, 32'h0);

    // R8 target offset and unmapped offset reads
    rd(TOF, r); check("R8 target read", r, TGT);
    rd(12'h198, r); check("R8 unmapped read", r, 32'h0);

    // R2 + R5: set then clear each vector in turn
    for (int v = 0; v < 32; v++) begin
      cycle(1, TGT, 32'(v), 0, '0, '0);
      model[v] = 1'b1;
      check_state("R2 R7");
      cycle(0, '0, '0, 1, STS, 32'h1 << v);
      model[v] = 1'b0;
      check_state("R5 R7");
    end

    // R2 accumulation of all vectors, R7 summary held
    for (int v = 31; v >= 0; v--) begin
      cycle(1, TGT, 32'(v), 0, '0, '0);
      model[v] = 1'b1;
    end
    check_state("R2 accumulate");

    // R5 writing zeros clears nothing; partial mask clears only its bits
    cycle(0, '0, '0, 1, STS, 32'h0);
    check_state("R5 zero write");
    cycle(0, '0, '0, 1, STS, 32'hA5A5_0F0F);
    model = model & ~32'hA5A5_0F0F;
    check_state("R5 partial");

    // R9 writes at other offsets
    cycle(0, '0, '0, 1, TOF, 32'hFFFF_FFFF);
    check_state("R9 target ofs");
    cycle(0, '0, '0, 1, 12'h000, 32'hFFFF_FFFF);
    check_state("R9 zero ofs");

    cycle(0, '0, '0, 1, STS, 32'hFFFF_FFFF);
    model = '0;
    check_state("R5 full clear");

    // R3 out-of-range vectors
    for (int d = 32; d < 64; d++) cycle(1, TGT, 32'(d), 0, '0, '0);
    cycle(1, TGT, 32'hFFFF_FFFF, 0, '0, '0);
    cycle(1, TGT, 32'h8000_0003, 0, '0, '0);
    check_state("R3 range");

    // R4 near-miss addresses
    for (int b = 0; b < 32; b++) cycle(1, TGT ^ (32'h1 << b), 32'(b), 0, '0, '0);
    cycle(1, 32'h194, 32'd1, 0, '0, '0);
    check_state("R4 addr");

    // R10 strobe low
    for (int v = 0; v < 32; v++) cycle(0, TGT, 32'(v), 0, '0, '0);
    check_state("R10 strobe");

    // R6 same-edge set and clear
    for (int v = 0; v < 32; v += 5) begin
      cycle(0, '0, '0, 1, STS, 32'hFFFF_FFFF);
      model = '0;
      cycle(1, TGT, 32'((v + 1) % 32), 0, '0, '0);
      model[(v + 1) % 32] = 1'b1;
      cycle(1, TGT, 32'(v), 1, STS, (32'h1 << v) | (32'h1 << ((v + 1) % 32)));
      model = 32'h1 << v;
      check_state("R6 race");
    end

    // R8 read returns pre-edge value when a set lands on the same edge
    cycle(0, '0, '0, 1, STS, 32'hFFFF_FFFF);
    model = '0;
    @(negedge clk);
    reg_rd_en = 1; reg_addr = STS; wr_valid = 1; wr_addr = TGT; wr_data = 32'd9;
    @(negedge clk);
    check("R8 pre-edge read", reg_rdata, 32'h0);
    idle();
    model[9] = 1'b1;
    check_state("R8 post");
    @(negedge clk);
    check("R8 idle rdata", reg_rdata, 32'h0);

    // R1 reset with pending bits
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model = '0;
    check_state("R1 re-reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule